// File: doc/BRIEF.md
# I2C Master START Condition Generator

This block produces the opening START condition of an I2C master transaction. Software writes a small control register whose bit 0 requests a START. The block waits on a reload-based baud timer, checks the bus lines, and pulls SDA low while SCL stays high. It then holds SDA low for one more timer period and signals completion. It guards its transmit buffer and control register while the START runs, and it reports a bus collision if another agent holds the lines or pulls SCL low too early.

SDA is driven through an open-drain style enable: `sda_oe` = 1 means the pad pulls SDA low. Both bus inputs pass through a two-flop synchronizer before any decision uses them. SCL is assumed to be released by other logic. After a successful START the block stays in a done state, with SDA held low, until reset. Byte transfer and the STOP that would follow belong to other blocks.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, `sda_oe`, all four flags, `ctl_q` and `buf_q` are 0.
- R2: Writing `ctl_q` with bit 0 (start enable) set while both synchronized lines are high loads the timer with divisor D (0..127). `sda_oe` and `start_seen` go to 1 on the D+2nd rising edge after the write edge.
- R3: D+1 edges after `sda_oe` rises, `irq` is set and `ctl_q[0]` clears. `sda_oe` then stays at 1.
- R4: A buffer write while `ctl_q[0]` is 1 sets `wcol` and leaves `buf_q` unchanged. A buffer write while `ctl_q[0]` is 0 stores the data and leaves `wcol` at 0.
- R5: A control write while `ctl_q[0]` is 1 is ignored, and all 5 bits keep their value. Once the START completes, a control write is stored again.
- R6: If both lines are low when the request is seen, `bcol` is set and `ctl_q[0]` clears. `sda_oe` never asserts.
- R7: If SCL goes low during the first timer period, `bcol` is set, `ctl_q[0]` clears and the START is abandoned. `sda_oe` stays 0 even after SCL returns high.
- R8: Each flag stays set until its clear strobe. If hardware sets a flag in the same cycle as its strobe, the set wins.
- R9: If exactly one line is low at the request, the request stays pending with no collision. It proceeds once both lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data; bit 0 requests a START |
| ctl_q | output | 5 | Control register contents |
| divisor | input | 7 | Baud timer reload value |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Transmit buffer write data |
| buf_q | output | 8 | Transmit buffer contents |
| sda_in | input | 1 | SDA pad level |
| scl_in | input | 1 | SCL pad level |
| sda_oe | output | 1 | 1 pulls SDA low |
| clr_start | input | 1 | Clears start_seen |
| clr_irq | input | 1 | Clears irq |
| clr_wcol | input | 1 | Clears wcol |
| clr_bcol | input | 1 | Clears bcol |
| start_seen | output | 1 | START was placed on the bus |
| irq | output | 1 | START sequence finished |
| wcol | output | 1 | Buffer write refused |
| bcol | output | 1 | Bus collision abort |

## Verification
The hardest case to reach is an SCL drop inside the first timer period. It has to land after the request has been accepted, and its two-cycle synchronized copy must arrive before the timer expires. The bench uses a large divisor so the window is wide. It models the wired bus so that `sda_oe` pulls the SDA it reads back, and lowers SCL a few cycles after the request. The set-over-clear ordering is reached by holding a clear strobe high for the whole sequence, so that it coincides with the set edge.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_HOLD  = 2'd2,
        PH_DONE  = 2'd3
    } phase_t;

    localparam int unsigned NUM_FLAGS = 4;
    localparam int unsigned FL_START  = 0;
    localparam int unsigned FL_IRQ    = 1;
    localparam int unsigned FL_WCOL   = 2;
    localparam int unsigned FL_BCOL   = 3;

    typedef struct packed {
        logic drop_en;
        logic tmr_load;
        logic tmr_halt;
        logic go_low;
        logic set_start;
        logic set_done;
        logic set_bcol;
    } seq_ctl_t;

    function automatic logic bus_free(input logic sda, input logic scl);
        return sda & scl;
    endfunction

    function automatic logic bus_held(input logic sda, input logic scl);
        return ~sda & ~scl;
    endfunction

endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d[g]};
            end
            assign q[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2cst_brg.sv
module i2cst_brg #(
    parameter int unsigned DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             halt,
    input  logic [DIV_W-1:0] div,
    output logic             running,
    output logic             expire
);
    logic [DIV_W-1:0] cnt;

    assign expire = running && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= div;
            running <= 1'b1;
        end else if (halt || expire) begin
            running <= 1'b0;
        end else if (running) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/i2cst_seq.sv
module i2cst_seq
    import i2cst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     sda_s,
    input  logic     scl_s,
    input  logic     expire,
    output seq_ctl_t ctl,
    output phase_t   phase,
    output logic     sda_drive
);
    phase_t phase_nx;

    always_comb begin
        ctl      = '0;
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: begin
                if (en) begin
                    if (bus_free(sda_s, scl_s)) begin
                        ctl.tmr_load = 1'b1;
                        phase_nx     = PH_SETUP;
                    end else if (bus_held(sda_s, scl_s)) begin
                        ctl.set_bcol = 1'b1;
                        ctl.drop_en  = 1'b1;
                    end
                end
            end
            PH_SETUP: begin
                if (!scl_s) begin
                    ctl.set_bcol = 1'b1;
                    ctl.drop_en  = 1'b1;
                    ctl.tmr_halt = 1'b1;
                    phase_nx     = PH_IDLE;
                end else if (expire) begin
                    if (sda_s) begin
                        ctl.go_low    = 1'b1;
                        ctl.set_start = 1'b1;
                        ctl.tmr_load  = 1'b1;
                        phase_nx      = PH_HOLD;
                    end else begin
                        ctl.set_bcol = 1'b1;
                        ctl.drop_en  = 1'b1;
                        ctl.tmr_halt = 1'b1;
                        phase_nx     = PH_IDLE;
                    end
                end
            end
            PH_HOLD: begin
                if (expire) begin
                    ctl.set_done = 1'b1;
                    ctl.drop_en  = 1'b1;
                    phase_nx     = PH_DONE;
                end
            end
            default: begin
                if (en) ctl.drop_en = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            sda_drive <= 1'b0;
        end else begin
            phase     <= phase_nx;
            sda_drive <= sda_drive | ctl.go_low;
        end
    end

    // R2
    drive_from_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive) |-> (phase == PH_HOLD));

    // R3
    hold_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD || phase == PH_DONE) |-> sda_drive);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
    import i2cst_pkg::*;
#(
    parameter int unsigned DIV_W   = 7,
    parameter int unsigned CTL_W   = 5,
    parameter int unsigned BUF_W   = 8,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic [DIV_W-1:0] divisor,
    input  logic             buf_wr,
    input  logic [BUF_W-1:0] buf_wdata,
    output logic [BUF_W-1:0] buf_q,
    input  logic             sda_in,
    input  logic             scl_in,
    output logic             sda_oe,
    input  logic             clr_start,
    input  logic             clr_irq,
    input  logic             clr_wcol,
    input  logic             clr_bcol,
    output logic             start_seen,
    output logic             irq,
    output logic             wcol,
    output logic             bcol
);
    logic [1:0]           lines_s;
    logic                 busy;
    logic                 expire;
    logic                 tmr_run;
    seq_ctl_t             sc;
    phase_t               phase;
    logic [NUM_FLAGS-1:0] fl_set;
    logic [NUM_FLAGS-1:0] fl_clr;
    logic [NUM_FLAGS-1:0] fl_q;

    assign busy = ctl_q[0];

    i2cst_sync #(.WIDTH(2), .STAGES(SYNC_ST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (lines_s)
    );

    i2cst_brg #(.DIV_W(DIV_W)) u_brg (
        .clk     (clk),
        .rst     (rst),
        .load    (sc.tmr_load),
        .halt    (sc.tmr_halt),
        .div     (divisor),
        .running (tmr_run),
        .expire  (expire)
    );

    i2cst_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (busy),
        .sda_s     (lines_s[0]),
        .scl_s     (lines_s[1]),
        .expire    (expire),
        .ctl       (sc),
        .phase     (phase),
        .sda_drive (sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst)                 ctl_q    <= '0;
        else if (sc.drop_en)     ctl_q[0] <= 1'b0;
        else if (ctl_wr && !busy) ctl_q   <= ctl_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                 buf_q <= '0;
        else if (buf_wr && !busy) buf_q <= buf_wdata;
    end

    assign fl_set[FL_START] = sc.set_start;
    assign fl_set[FL_IRQ]   = sc.set_done;
    assign fl_set[FL_WCOL]  = buf_wr && busy;
    assign fl_set[FL_BCOL]  = sc.set_bcol;
    assign fl_clr = {clr_bcol, clr_wcol, clr_irq, clr_start};

    genvar f;
    generate
        for (f = 0; f < NUM_FLAGS; f++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) fl_q[f] <= 1'b0;
                else     fl_q[f] <= fl_set[f] | (fl_q[f] & ~fl_clr[f]);
            end
        end
    endgenerate

    assign start_seen = fl_q[FL_START];
    assign irq        = fl_q[FL_IRQ];
    assign wcol       = fl_q[FL_WCOL];
    assign bcol       = fl_q[FL_BCOL];

    // R4
    buf_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && busy) |=> $stable(buf_q));

    // R5
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !sc.drop_en) |=> $stable(ctl_q));

    // R3
    done_after_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (sda_oe && !busy));

    // R7
    bcol_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bcol) |-> (!sda_oe && !busy));

    // R2
    setup_timed_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETUP) |-> tmr_run);
endmodule

// File: tb/i2c_start_gen_tb.sv
module i2c_start_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [4:0] ctl_wdata = '0;
    logic [4:0] ctl_q;
    logic [6:0] divisor = '0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic [7:0] buf_q;
    logic       sda_tb = 1'b1;
    logic       scl_tb = 1'b1;
    logic       sda_oe;
    logic       clr_start = 1'b0, clr_irq = 1'b0, clr_wcol = 1'b0, clr_bcol = 1'b0;
    logic       start_seen, irq, wcol, bcol;
    logic       sda_in, scl_in;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    assign sda_in = sda_oe ? 1'b0 : sda_tb;
    assign scl_in = scl_tb;

    always #10 clk = ~clk;

    i2c_start_gen u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .divisor(divisor), .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_q(buf_q),
        .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe),
        .clr_start(clr_start), .clr_irq(clr_irq), .clr_wcol(clr_wcol), .clr_bcol(clr_bcol),
        .start_seen(start_seen), .irq(irq), .wcol(wcol), .bcol(bcol)
    );

    // divisor, expected edges to sda_oe, expected edges to irq
    localparam int NV = 5;
    localparam int VEC [NV][3] = '{
        '{0,   2,   3},
        '{1,   3,   5},
        '{5,   7,  13},
        '{20, 22,  43},
        '{127, 129, 257}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sda_tb = 1'b1; scl_tb = 1'b1;
        ctl_wr = 1'b0; buf_wr = 1'b0;
        clr_start = 1'b0; clr_irq = 1'b0; clr_wcol = 1'b0; clr_bcol = 1'b0;
        step(3);
        rst = 1'b0;
        step(3);
    endtask

    task automatic ctl_write(input logic [4:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(posedge clk);
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic buf_write(input logic [7:0] v);
        buf_wr = 1'b1; buf_wdata = v;
        @(posedge clk);
        @(negedge clk);
        buf_wr = 1'b0;
    endtask

    initial begin
        int n;
        do_reset();
        // R1
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 flags", {start_seen, irq, wcol, bcol}, 0);
        chk("R1 ctl_q", ctl_q, 0);
        chk("R1 buf_q", buf_q, 0);

        // R2 / R3 vector walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            divisor = 7'(VEC[v][0]);
            ctl_write(5'h01);
            n = 0;
            while (!sda_oe && n < 400) begin step(1); n++; end
            chk($sformatf("R2 oe edges d=%0d", VEC[v][0]), n, VEC[v][1]);
            chk("R2 start_seen", start_seen, 1);
            while (!irq && n < 800) begin step(1); n++; end
            chk($sformatf("R3 irq edges d=%0d", VEC[v][0]), n, VEC[v][2]);
            chk("R3 enable cleared", ctl_q[0], 0);
            step(5);
            chk("R3 sda held", sda_oe, 1);
        end

        // R4 / R5
        do_reset();
        buf_write(8'hA5);
        chk("R4 idle write", buf_q, 8'hA5);
        chk("R4 no wcol", wcol, 0);
        divisor = 7'd30;
        ctl_write(5'h01);
        step(2);
        buf_write(8'h3C);
        chk("R4 wcol set", wcol, 1);
        chk("R4 buffer kept", buf_q, 8'hA5);
        ctl_write(5'h1E);
        chk("R5 ctl kept", ctl_q, 5'h01);
        clr_wcol = 1'b1; step(1); clr_wcol = 1'b0;
        chk("R8 wcol cleared", wcol, 0);
        n = 0;
        while (!irq && n < 200) begin step(1); n++; end
        ctl_write(5'h1A);
        chk("R5 ctl after done", ctl_q, 5'h1A);
        clr_start = 1'b1; step(1); clr_start = 1'b0;
        chk("R8 start cleared", start_seen, 0);
        chk("R8 irq sticky", irq, 1);

        // R6
        do_reset();
        sda_tb = 1'b0; scl_tb = 1'b0;
        step(4);
        divisor = 7'd3;
        ctl_write(5'h01);
        step(4);
        chk("R6 bcol", bcol, 1);
        chk("R6 enable cleared", ctl_q[0], 0);
        chk("R6 no drive", sda_oe, 0);

        // R7
        do_reset();
        divisor = 7'd50;
        ctl_write(5'h01);
        step(10);
        scl_tb = 1'b0;
        step(6);
        chk("R7 bcol", bcol, 1);
        chk("R7 enable cleared", ctl_q[0], 0);
        scl_tb = 1'b1;
        step(80);
        chk("R7 no drive", sda_oe, 0);
        clr_bcol = 1'b1; step(1); clr_bcol = 1'b0;
        chk("R8 bcol cleared", bcol, 0);

        // R9
        do_reset();
        sda_tb = 1'b0;
        step(4);
        divisor = 7'd2;
        ctl_write(5'h01);
        step(10);
        chk("R9 no bcol", bcol, 0);
        chk("R9 pending", ctl_q[0], 1);
        chk("R9 no drive", sda_oe, 0);
        sda_tb = 1'b1;
        n = 0;
        while (!sda_oe && n < 50) begin step(1); n++; end
        chk("R9 proceeds", sda_oe, 1);

        // R8 set wins over simultaneous clear
        do_reset();
        divisor = 7'd3;
        clr_irq = 1'b1;
        ctl_write(5'h01);
        n = 0;
        while (!irq && n < 50) begin step(1); n++; end
        chk("R8 set wins", irq, 1);
        step(1);
        chk("R8 later clear", irq, 0);
        clr_irq = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule